// File: doc/BRIEF.md
# I2C Bus Status and Start Control Register

This block is the 8-bit status and configuration register of an I2C controller. It keeps a bus-busy flag that follows start and stop conditions reported by the line detectors. It also keeps a sticky flag that records a start request that could not be issued. It holds the level-type start request that software raises, plus two configuration bits that software sets while the controller is disabled. The first configuration bit lets the first start go out without first seeing a stop. The second turns off start reservation, so a start that cannot be generated is dropped and not kept waiting.

The controller around the block supplies the enable level, the detector pulses and the outcome of each start attempt. The CPU reads the packed value and writes the configuration bits through a plain write port. The bus line drivers, the condition detectors and the shift logic are outside this block.

Top module: `i2c_bus_status_reg`

## Requirements
- R1: After reset every bit of `rdata` is 0 and `start_pending` is 0. Bits 5 down to 2 of `rdata` always read 0. The layout is: bit 7 start-failed, bit 6 bus-busy, bit 1 initial-start-enable, bit 0 reservation-disable.
- R2: A CPU write never changes bits 7 and 6 of `rdata`, whatever value `wdata` carries.
- R3: While enabled, a `start_det` pulse sets bus-busy and a `stop_det` pulse clears it. Each flag takes its new value on the clock edge that ends the cycle in which the event is present.
- R4: While `periph_en` is 0, bus-busy, start-failed and `start_pending` are held at 0, and no detector, request or failure pulse can set them.
- R5: On the first enabled cycle after a disabled one, bus-busy is set if initial-start-enable is 0. It stays 0 if initial-start-enable is 1.
- R6: A `start_fail` pulse while enabled and reservation-disable is 1 sets start-failed and clears `start_pending`. With reservation-disable at 0 the pulse changes neither of them.
- R7: A `sw_start_req` pulse while enabled clears start-failed.
- R8: A `start_det` pulse clears initial-start-enable.
- R9: A write to `rdata` bits 1 and 0 through `wr_en`/`wdata` takes effect only while `periph_en` is 0. While it is 1 the write is ignored.
- R10: When a set event and a clear event reach the same bit in the same cycle, the bit ends up 0 (stop against start for bus-busy, request against failure for start-failed, completion or failure against request for `start_pending`).
- R11: `start_pending` rises after a `sw_start_req` pulse while enabled and stays 1 until a `start_done` pulse, a cancelling failure (R6) or disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Controller enable level |
| sw_start_req | input | 1 | Software start request pulse |
| start_det | input | 1 | Start condition detected pulse |
| stop_det | input | 1 | Stop condition detected pulse |
| start_fail | input | 1 | Start generation unsuccessful pulse |
| start_done | input | 1 | Start condition generated pulse |
| wr_en | input | 1 | CPU write strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Packed register read value |
| bus_busy | output | 1 | Bus-busy flag |
| start_failed | output | 1 | Sticky start-failed flag |
| init_start_en | output | 1 | Initial-start-enable configuration bit |
| rsv_disable | output | 1 | Reservation-disable configuration bit |
| start_pending | output | 1 | Outstanding start request level |

## Verification
The properties assume that every event input is a pulse already synchronous to `clk`. They also assume that `start_done` and `start_fail` never describe the same attempt in one cycle. The stimulus drives each event for exactly one cycle from the falling edge. It never asserts those two outcomes together. It covers the defined collisions on purpose: start against stop, request against failure, and enable against a pending request.

// File: rtl/i2c_bus_status_reg.sv
module i2c_bus_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periph_en,
  input  logic       sw_start_req,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       start_fail,
  input  logic       start_done,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       bus_busy,
  output logic       start_failed,
  output logic       init_start_en,
  output logic       rsv_disable,
  output logic       start_pending
);

  logic en_q;
  logic en_rise;
  logic cfg_wr;
  logic fail_hit;

  assign en_rise  = periph_en & ~en_q;
  assign cfg_wr   = wr_en & ~periph_en;
  assign fail_hit = start_fail & rsv_disable;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= periph_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          bus_busy <= 1'b0;
    else if (!periph_en || stop_det)     bus_busy <= 1'b0;
    else if (start_det)                  bus_busy <= 1'b1;
    else if (en_rise && !init_start_en)  bus_busy <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          start_failed <= 1'b0;
    else if (!periph_en || sw_start_req) start_failed <= 1'b0;
    else if (fail_hit)                   start_failed <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                      start_pending <= 1'b0;
    else if (!periph_en || start_done || fail_hit)   start_pending <= 1'b0;
    else if (sw_start_req)                           start_pending <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         init_start_en <= 1'b0;
    else if (start_det) init_start_en <= 1'b0;
    else if (cfg_wr)    init_start_en <= wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rsv_disable <= 1'b0;
    else if (cfg_wr) rsv_disable <= wdata[0];

  assign rdata = {start_failed, bus_busy, 4'b0000, init_start_en, rsv_disable};

endmodule

// File: rtl/i2c_bus_status_chk.sv
module i2c_bus_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       periph_en,
  input logic       sw_start_req,
  input logic       start_det,
  input logic       stop_det,
  input logic       start_fail,
  input logic       start_done,
  input logic       bus_busy,
  input logic       start_failed,
  input logic       init_start_en,
  input logic       rsv_disable,
  input logic       start_pending
);

  a_r3_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && start_det && !stop_det |=> bus_busy);

  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && stop_det |=> !bus_busy);

  a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> !bus_busy && !start_failed && !start_pending);

  a_r6_fail_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && start_fail && rsv_disable && !sw_start_req |=> start_failed && !start_pending);

  a_r7_req_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && sw_start_req |=> !start_failed);

  a_r8_start_clears_ise: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !init_start_en);

  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en |=> $stable(rsv_disable));

  a_r11_req_pends: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en && sw_start_req && !start_done && !start_fail |=> start_pending);

endmodule

bind i2c_bus_status_reg i2c_bus_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .sw_start_req(sw_start_req),
  .start_det(start_det), .stop_det(stop_det), .start_fail(start_fail),
  .start_done(start_done), .bus_busy(bus_busy), .start_failed(start_failed),
  .init_start_en(init_start_en), .rsv_disable(rsv_disable),
  .start_pending(start_pending)
);

// File: tb/i2c_bus_status_reg_tb.sv
module i2c_bus_status_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       periph_en = 1'b0, sw_start_req = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic       start_fail = 1'b0, start_done = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       bus_busy, start_failed, init_start_en, rsv_disable, start_pending;

  typedef struct {
    logic [7:0] rd;
    logic       pend;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  i2c_bus_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .sw_start_req(sw_start_req),
    .start_det(start_det), .stop_det(stop_det), .start_fail(start_fail),
    .start_done(start_done), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .bus_busy(bus_busy), .start_failed(start_failed), .init_start_en(init_start_en),
    .rsv_disable(rsv_disable), .start_pending(start_pending)
  );

  task automatic step(input logic en, input logic req, input logic sd, input logic pd,
                      input logic fl, input logic dn, input logic wr, input logic [7:0] wd,
                      input logic [7:0] erd, input logic epend, input string tag);
    exp_t e;
    @(negedge clk);
    periph_en = en; sw_start_req = req; start_det = sd; stop_det = pd;
    start_fail = fl; start_done = dn; wr_en = wr; wdata = wd;
    e.rd = erd; e.pend = epend; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rdata !== e.rd || start_pending !== e.pend ||
          bus_busy !== e.rd[6] || start_failed !== e.rd[7] ||
          init_start_en !== e.rd[1] || rsv_disable !== e.rd[0]) begin
        errors++;
        $display("FAIL %s: rdata=%02h pend=%b expected rdata=%02h pend=%b",
                 e.tag, rdata, start_pending, e.rd, e.pend);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (rdata !== 8'h00 || start_pending !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: rdata=%02h pend=%b expected rdata=00 pend=0", rdata, start_pending);
    end
    rst_n = 1'b1;
    //    en req sd pd fl dn wr wd     rdata  pend
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, "R1 idle after reset");
    step(0, 0, 0, 0, 0, 0, 1, 8'hFF, 8'h03, 0, "R2 R1 write all ones");
    step(0, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00, 0, "R9 write zero while disabled");
    step(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h40, 0, "R5 enable preloads busy");
    step(1, 0, 0, 0, 0, 0, 1, 8'h03, 8'h40, 0, "R9 write ignored while enabled");
    step(1, 0, 0, 1, 0, 0, 0, 8'h00, 8'h00, 0, "R3 stop clears busy");
    step(1, 0, 1, 0, 0, 0, 0, 8'h00, 8'h40, 0, "R3 start sets busy");
    step(1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00, 0, "R10 stop wins over start");
    step(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 1, "R11 request raises pending");
    step(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 1, "R11 pending holds");
    step(1, 0, 0, 0, 0, 1, 0, 8'h00, 8'h00, 0, "R11 start_done clears pending");
    step(0, 0, 0, 0, 0, 0, 1, 8'h01, 8'h01, 0, "R9 set reservation-disable");
    step(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h41, 0, "R5 re-enable preloads busy");
    step(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h41, 1, "R11 request again");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'hC1, 0, "R6 failure sets flag and cancels");
    step(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'hC1, 0, "R2 R6 flag sticky, write ignored");
    step(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h41, 1, "R7 new request clears flag");
    step(1, 1, 0, 0, 1, 0, 0, 8'h00, 8'h41, 0, "R10 request and failure collide");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'hC1, 0, "R6 failure alone");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h01, 0, "R4 disable clears flags");
    step(0, 1, 1, 0, 1, 0, 0, 8'h00, 8'h01, 0, "R4 events ignored while disabled");
    step(0, 0, 0, 0, 0, 0, 1, 8'h02, 8'h02, 0, "R9 set initial-start-enable");
    step(1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h02, 0, "R5 initial start: no preload");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h02, 0, "R6 failure without disable ignored");
    step(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h02, 1, "R11 request pending");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h02, 1, "R6 no cancel with reservation");
    step(1, 0, 1, 0, 0, 0, 0, 8'h00, 8'h40, 1, "R8 start clears initial-start-enable");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, "R4 disable drops request");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, 0, "R1 final idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule